// File: doc/BRIEF.md
# Mode-Controlled GPIO Port Register

This block is an eight-pin general-purpose I/O port with two addressable registers on a simple synchronous register bus. One register holds a data latch with one bit per pin. The other holds a two-bit mode code for every pin, and that code decides where a read of the pin's bit comes from and what drives the pin. Depending on its mode, each pin shows either the latch or the synchronized pin level on a data read. Each pin also produces an output value, an output enable and a pull-up enable for its pad. A pin in alternate mode passes the alternate-function output and enable straight through to the pad.

Two bit positions, pins 4 and 6, are input-only. Their latch bits ignore writes and stay zero. On these pins the output mode is treated as input without pull-up, so the block never drives them. Pin levels pass through a synchronizer before they can be read.

Top module: `gpio_mode_port`

## Requirements
- R1: After reset the data latch reads 0x00, the mode register reads 0x0000 (every pin in alternate mode), and pull-up enables are all low.
- R2: The mode register sits at bus address 1 and is 16 bits wide. Pin n's code is in bits [2n+1:2n], and a written value reads back unchanged.
- R3: A pin with code 01 (general output) has its output enable high and drives its latch bit. Its data-read bit is the latch bit. A write to the data register at address 0 lands in the latch on the next clock edge.
- R4: A pin with code 00 (alternate) takes its pad output and output enable from the alternate-function inputs. Its data-read bit is the latch bit.
- R5: A pin with code 10 or 11 (input) has its output enable low, and its data-read bit is the synchronized pin level. A data write still updates the latch, and the new value shows once the pin is switched to code 01.
- R6: Pull-up enable is high only for a pin whose effective code is 10.
- R7: Bits 4 and 6 of the data latch ignore writes and stay 0.
- R8: On pins 4 and 6, code 01 acts as code 11: output enable and pull-up stay low, and the data-read bit is the synchronized pin level.
- R9: A pin level change appears on a data read after two rising clock edges, and not after one.
- R10: Registers change only on a clock edge with write enable high and a matching address. Reads of any address other than 0 and 1 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 2 | Register address: 0 data, 1 mode |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data |
| pin_in | input | 8 | Pad input levels, asynchronous |
| alt_out | input | 8 | Alternate-function output values |
| alt_oe | input | 8 | Alternate-function output enables |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| pin_pu | output | 8 | Pad pull-up enables |

## Verification
Register writes become visible one rising edge after the write cycle. Pad controls that follow from the mode register are due in the same cycle as the mode write. Alternate-mode pass-through is combinational, with no edge needed. A pin level needs two rising edges before a data read shows it. The bench changes inputs on falling edges and samples on later falling edges. It waits at least three edges before comparing table results, and for the latency test it samples exactly after one edge and again after two.

// File: rtl/gpio_mode_pkg.sv
package gpio_mode_pkg;
   typedef enum logic [1:0] {
      PM_ALT     = 2'b00,
      PM_OUT     = 2'b01,
      PM_IN_PU   = 2'b10,
      PM_IN_NOPU = 2'b11
   } pin_mode_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio_sync needs at least two stages");
      end
   endgenerate

   logic [WIDTH-1:0] stage_q [STAGES];
   logic             armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
         armed_q <= 1'b0;
      end else begin
         stage_q[0] <= async_i;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
         armed_q <= 1'b1;
      end
   end

   assign sync_o = stage_q[STAGES-1];

   // R9: first stage captures the pad once out of reset
   p_first_stage_r9: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
      stage_q[0] == $past(async_i));

   genvar g;
   generate
      for (g = 1; g < STAGES; g++) begin : g_chk
         // R9: every later stage is one edge behind the one before
         p_stage_shift_r9: assert property (@(posedge clk) disable iff (!rst_n)
            stage_q[g] == $past(stage_q[g-1]));
      end
   endgenerate
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
   import gpio_mode_pkg::*;
#(
   parameter bit READ_ONLY = 1'b0
) (
   input  logic [1:0] mode_i,
   input  logic       latch_i,
   input  logic       pin_sync_i,
   input  logic       alt_out_i,
   input  logic       alt_oe_i,
   output logic       rd_o,
   output logic       out_o,
   output logic       oe_o,
   output logic       pu_o
);
   pin_mode_e eff_mode;

   generate
      if (READ_ONLY) begin : g_ro
         always_comb begin
            eff_mode = pin_mode_e'(mode_i);
            if (eff_mode == PM_OUT) eff_mode = PM_IN_NOPU;
         end
      end else begin : g_rw
         assign eff_mode = pin_mode_e'(mode_i);
      end
   endgenerate

   always_comb begin
      rd_o  = latch_i;
      out_o = latch_i;
      oe_o  = 1'b0;
      pu_o  = 1'b0;
      unique case (eff_mode)
         PM_ALT: begin
            out_o = alt_out_i;
            oe_o  = alt_oe_i;
         end
         PM_OUT:     oe_o = 1'b1;
         PM_IN_PU: begin
            rd_o = pin_sync_i;
            pu_o = 1'b1;
         end
         PM_IN_NOPU: rd_o = pin_sync_i;
         default: ;
      endcase
   end
endmodule

// File: rtl/gpio_mode_port.sv
module gpio_mode_port
   import gpio_mode_pkg::*;
#(
   parameter int               PIN_COUNT   = 8,
   parameter int               ADDR_W      = 2,
   parameter int               BUS_W       = 16,
   parameter int               DATA_ADDR   = 0,
   parameter int               MODE_ADDR   = 1,
   parameter int               SYNC_STAGES = 2,
   parameter logic [PIN_COUNT-1:0] RO_MASK = 8'b0101_0000
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 bus_we,
   input  logic [BUS_W-1:0]     bus_wdata,
   output logic [BUS_W-1:0]     bus_rdata,
   input  logic [PIN_COUNT-1:0] pin_in,
   input  logic [PIN_COUNT-1:0] alt_out,
   input  logic [PIN_COUNT-1:0] alt_oe,
   output logic [PIN_COUNT-1:0] pin_out,
   output logic [PIN_COUNT-1:0] pin_oe,
   output logic [PIN_COUNT-1:0] pin_pu
);
   localparam int MODE_W = 2 * PIN_COUNT;

   generate
      if (MODE_W > BUS_W) begin : g_bad_bus
         $error("bus too narrow for the mode register");
      end
      if (DATA_ADDR == MODE_ADDR) begin : g_bad_addr
         $error("data and mode registers share an address");
      end
      if (DATA_ADDR >= (1 << ADDR_W) || MODE_ADDR >= (1 << ADDR_W)) begin : g_bad_range
         $error("register address out of range");
      end
   endgenerate

   logic                 wr_data, wr_mode;
   logic [PIN_COUNT-1:0] data_q;
   logic [MODE_W-1:0]    mode_q;
   logic [PIN_COUNT-1:0] pin_sync;
   logic [PIN_COUNT-1:0] rd_bits;

   assign wr_data = bus_we && (bus_addr == ADDR_W'(DATA_ADDR));
   assign wr_mode = bus_we && (bus_addr == ADDR_W'(MODE_ADDR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mode_q <= '0;
      else if (wr_mode) mode_q <= bus_wdata[MODE_W-1:0];
   end

   gpio_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) sync_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (pin_in),
      .sync_o  (pin_sync)
   );

   genvar n;
   generate
      for (n = 0; n < PIN_COUNT; n++) begin : g_pin
         if (RO_MASK[n]) begin : g_latch_ro
            assign data_q[n] = 1'b0;
         end else begin : g_latch_rw
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)       data_q[n] <= 1'b0;
               else if (wr_data) data_q[n] <= bus_wdata[n];
            end
         end

         gpio_pin_cell #(.READ_ONLY(RO_MASK[n])) cell_i (
            .mode_i     (mode_q[2*n +: 2]),
            .latch_i    (data_q[n]),
            .pin_sync_i (pin_sync[n]),
            .alt_out_i  (alt_out[n]),
            .alt_oe_i   (alt_oe[n]),
            .rd_o       (rd_bits[n]),
            .out_o      (pin_out[n]),
            .oe_o       (pin_oe[n]),
            .pu_o       (pin_pu[n])
         );

         // R6: pull-up only with code 10 in the mode register
         p_pu_only_in10_r6: assert property (@(posedge clk) disable iff (!rst_n)
            pin_pu[n] |-> (mode_q[2*n +: 2] == 2'b10));
         // R4: alternate mode passes the alternate enable to the pad
         p_alt_oe_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[2*n +: 2] == 2'b00) |-> (pin_oe[n] == alt_oe[n]));
         if (RO_MASK[n]) begin : g_ro_chk
            // R8: input-only pins are never driven outside alternate mode
            p_ro_never_oe_r8: assert property (@(posedge clk) disable iff (!rst_n)
               (mode_q[2*n +: 2] != 2'b00) |-> !pin_oe[n]);
         end
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(DATA_ADDR))      bus_rdata[PIN_COUNT-1:0] = rd_bits;
      else if (bus_addr == ADDR_W'(MODE_ADDR)) bus_rdata[MODE_W-1:0]    = mode_q;
   end

   // R3: a data write lands in the latch on the next edge, masked by R7
   p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_data |=> (data_q == ($past(bus_wdata[PIN_COUNT-1:0]) & ~RO_MASK)));
   // R7: input-only latch bits remain zero
   p_ro_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (data_q & RO_MASK) == '0);
   // R10: no write strobe, no change
   p_hold_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_data |=> $stable(data_q));
   p_hold_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_mode |=> $stable(mode_q));
endmodule

// File: tb/gpio_mode_port_tb.sv
module gpio_mode_port_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 5;

   typedef struct packed {
      logic [15:0] mode;
      logic [7:0]  wdata;
      logic [7:0]  pin;
      logic [7:0]  aout;
      logic [7:0]  aoe;
      logic [7:0]  exp_rd;
      logic [7:0]  exp_oe;
      logic [7:0]  exp_pu;
      logic [7:0]  exp_out;
   } vec_t;

   // Latch after a write is wdata & 8'hAF (bits 4 and 6 ignore writes)
   localparam vec_t VECS [NVEC] = '{
      '{16'h5555, 8'hFF, 8'h00, 8'h00, 8'h00, 8'hAF, 8'hAF, 8'h00, 8'hAF}, // R3 R8 all output
      '{16'hAAAA, 8'h00, 8'h5A, 8'h00, 8'h00, 8'h5A, 8'h00, 8'hFF, 8'h00}, // R5 R6 input pull-up
      '{16'hFFFF, 8'hC3, 8'h3C, 8'h00, 8'h00, 8'h3C, 8'h00, 8'h00, 8'h83}, // R5 input no pull-up
      '{16'h0000, 8'h5A, 8'hFF, 8'h96, 8'h0F, 8'h0A, 8'h0F, 8'h00, 8'h96}, // R4 R7 alternate
      '{16'h61E4, 8'hFF, 8'h50, 8'hFF, 8'hFF, 8'hF3, 8'hA3, 8'h44, 8'hAF}  // mixed codes R8
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [7:0]  pin_in = '0, alt_out = '0, alt_oe = '0;
   logic [7:0]  pin_out, pin_oe, pin_pu;
   int checks = 0, errors = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_mode_port dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .alt_out(alt_out), .alt_oe(alt_oe), .pin_out(pin_out),
      .pin_oe(pin_oe), .pin_pu(pin_pu)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_we = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] rd;
      repeat (3) @(negedge clk);
      // R1 reset state
      bus_read(2'd0, rd); check("R1 data", rd, 16'h0000);
      bus_read(2'd1, rd); check("R1 mode", rd, 16'h0000);
      check("R1 pull-up", {8'h00, pin_pu}, 16'h0000);
      @(negedge clk) rst_n = 1'b1;

      // Table walk
      for (int v = 0; v < NVEC; v++) begin
         bus_write(2'd1, VECS[v].mode);
         bus_write(2'd0, {8'h00, VECS[v].wdata});
         pin_in = VECS[v].pin; alt_out = VECS[v].aout; alt_oe = VECS[v].aoe;
         repeat (3) @(negedge clk);
         bus_read(2'd0, rd);
         check($sformatf("R3/R5 read vec%0d", v), rd, {8'h00, VECS[v].exp_rd});
         check($sformatf("R4/R8 oe vec%0d", v), {8'h00, pin_oe}, {8'h00, VECS[v].exp_oe});
         check($sformatf("R6 pu vec%0d", v), {8'h00, pin_pu}, {8'h00, VECS[v].exp_pu});
         check($sformatf("R4 out vec%0d", v), {8'h00, pin_out}, {8'h00, VECS[v].exp_out});
      end

      // R2 mode readback
      bus_write(2'd1, 16'h1B2D);
      bus_read(2'd1, rd); check("R2 mode readback", rd, 16'h1B2D);

      // R9 two-edge latency, all pins input without pull-up
      bus_write(2'd1, 16'hFFFF);
      pin_in = 8'h00;
      repeat (3) @(negedge clk);
      pin_in = 8'hFF;
      @(negedge clk);
      bus_read(2'd0, rd); check("R9 after one edge", rd, 16'h0000);
      @(negedge clk);
      bus_read(2'd0, rd); check("R9 after two edges", rd, 16'h00FF);

      // R5 write in input mode updates the latch
      bus_write(2'd0, 16'h000F);
      bus_read(2'd0, rd); check("R5 input read ignores latch", rd, 16'h00FF);
      bus_write(2'd1, 16'h5555);
      bus_read(2'd0, rd); check("R5 latch seen in output", rd, 16'h00AF & 16'h000F | 16'h0050);
      check("R5 pad out", {8'h00, pin_out}, 16'h000F);

      // R7 write to read-only bits with pins low
      pin_in = 8'h00;
      repeat (3) @(negedge clk);
      bus_write(2'd1, 16'h0000);
      bus_write(2'd0, 16'h0050);
      bus_read(2'd0, rd); check("R7 ro bits ignore writes", rd, 16'h0000);

      // R10 write enable low and unmapped address
      bus_write(2'd0, 16'h0003);
      @(negedge clk);
      bus_addr = 2'd0; bus_wdata = 16'h00FF; bus_we = 1'b0;
      @(negedge clk);
      bus_read(2'd0, rd); check("R10 we low ignored", rd, 16'h0003);
      bus_write(2'd2, 16'hFFFF);
      bus_read(2'd0, rd); check("R10 unmapped write data", rd, 16'h0003);
      bus_read(2'd1, rd); check("R10 unmapped write mode", rd, 16'h0000);
      bus_read(2'd2, rd); check("R10 unmapped read", rd, 16'h0000);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule